// File: doc/BRIEF.md
# Event Scaler Bank with Coherent Timestamp Snapshot

This block keeps one free-running event counter per input channel (32 channels, 32 bits each by default) beside a free-running timestamp counter of the same width. The timestamp advances by one on every clock, so the block is meant to be clocked from the 20 MHz timestamp clock. Each event input is already synchronised to that clock and adds one to its counter in every cycle it is high.

Software reads the block through a register index (the byte address divided by 4) with single-cycle read and write strobes. Reading index 6 returns the current timestamp. In that same cycle the block copies every counter into its own shadow register, so all 32 values refer to one instant. Software then reads the shadows one at a time at indexes 16 and up. Writing index 6 clears all counters and leaves the timestamp running. Read data comes back one cycle after the strobe and is marked by `rd_valid`. Reads and writes are always accepted and there is no back-pressure: the requester holds no ready signal and must take `rd_data` in the cycle `rd_valid` is high.

Top module: `scaler_snap_bank`

## Requirements
- R1: After reset, every counter, every shadow register and the timestamp are zero, and `rd_valid` is low.
- R2: The timestamp increases by exactly one on every clock after reset, wraps from all ones to zero, and is never changed by any write.
- R3: A read of index 6 returns the timestamp value held in the strobe cycle, presented on `rd_data` in the next cycle.
- R4: A read of index 6 loads every shadow register with its counter's value as held in the strobe cycle, all in the same clock edge. Without such a read the shadows do not change.
- R5: Each counter adds one in every cycle its event input is high and wraps modulo 2^32. Counting continues during a snapshot, so an event in the snapshot cycle appears in the next snapshot.
- R6: A write to index 6 resets all counters. An event present in the clear cycle is kept, so that counter then holds 1 rather than 0.
- R7: Reads of index 16+k return shadow k for k = 0..31. Indexes 16..31 hold channels 0..15 (first input bank), and indexes 32..47 hold channels 16..31 (second input bank).
- R8: Reads of any other index return zero. Writes to any index other than 6 change no counter, shadow or timestamp.
- R9: `rd_valid` is high in exactly the cycle after each read strobe. A read and a write of index 6 in the same cycle capture the pre-clear counter values into the shadows and also clear the counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timestamp-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_in | input | NUM_CH (32) | Synchronised event inputs, one per counter |
| reg_idx | input | IDX_W (6) | Register index (byte address / 4) |
| rd_en | input | 1 | Read strobe, one cycle |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | CNT_W (32) | Read data |

## Verification
Three things can land on one clock edge: the snapshot, the counter clear, and the counting of an event. The hardest case is a read and a write of index 6 in one cycle while events are also arriving. The bench provokes it with directed cycles that combine all three, and it also produces random collisions by mixing snapshot reads, clear writes and dense random event patterns. A cycle-stepped model in the bench judges each case. It predicts the shadows from the counters before the edge, and it predicts that the cleared counters keep only the events from the clear cycle. Every shadow is then read back and compared.

// File: rtl/scaler_snap_pkg.sv
package scaler_snap_pkg;
  // Register index map (byte address = index * 4)
  localparam int TS_INDEX    = 6;   // timestamp read / snapshot, counter clear on write
  localparam int SHADOW_BASE = 16;  // first shadow register index

  typedef struct packed {
    logic snap;   // copy counters into shadows
    logic clear;  // reset counters
  } bank_ctl_t;
endpackage

// File: rtl/scaler_snap_ts.sv
module scaler_snap_ts #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] ts
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts <= '0;
    else        ts <= ts + 1'b1;
  end
endmodule

// File: rtl/scaler_snap_counter.sv
module scaler_snap_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev,
  input  logic             clear,
  input  logic             snap,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] shadow
);
  logic [CNT_W-1:0] inc;
  assign inc = {{(CNT_W-1){1'b0}}, ev};

  // Clear keeps the event of the clear cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= inc;
    else            cnt <= cnt + inc;
  end

  // Shadow takes the value before this cycle's event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    shadow <= '0;
    else if (snap) shadow <= cnt;
  end
endmodule

// File: rtl/scaler_snap_rdmux.sv
module scaler_snap_rdmux
  import scaler_snap_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int CNT_W  = 32,
  parameter int IDX_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [CNT_W-1:0] ts,
  input  logic [CNT_W-1:0] shadow [NUM_CH],
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_data
);
  localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [IDX_W-1:0] rel;
  logic [SEL_W-1:0] sel;
  logic             in_bank;
  logic [CNT_W-1:0] rd_next;

  assign rel     = reg_idx - IDX_W'(SHADOW_BASE);
  assign sel     = rel[SEL_W-1:0];
  assign in_bank = (int'(reg_idx) >= SHADOW_BASE) &&
                   (int'(reg_idx) <  SHADOW_BASE + NUM_CH);

  always_comb begin
    rd_next = '0;
    if (int'(reg_idx) == TS_INDEX) rd_next = ts;
    else if (in_bank)              rd_next = shadow[sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/scaler_snap_bank.sv
module scaler_snap_bank
  import scaler_snap_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int CNT_W  = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ev_in,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic              rd_en,
  input  logic              wr_en,
  output logic              rd_valid,
  output logic [CNT_W-1:0]  rd_data
);
  localparam int TOP_IDX = SHADOW_BASE + NUM_CH - 1;

  if (TOP_IDX >= (1 << IDX_W)) begin : g_bad_idx_w
    $error("IDX_W too narrow for the shadow register range");
  end

  bank_ctl_t        ctl;
  logic [CNT_W-1:0] ts_q;
  logic [CNT_W-1:0] cnt_q    [NUM_CH];
  logic [CNT_W-1:0] shadow_q [NUM_CH];

  assign ctl.snap  = rd_en && (int'(reg_idx) == TS_INDEX);
  assign ctl.clear = wr_en && (int'(reg_idx) == TS_INDEX);

  scaler_snap_ts #(.CNT_W(CNT_W)) u_ts (
    .clk   (clk),
    .rst_n (rst_n),
    .ts    (ts_q)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    scaler_snap_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev     (ev_in[i]),
      .clear  (ctl.clear),
      .snap   (ctl.snap),
      .cnt    (cnt_q[i]),
      .shadow (shadow_q[i])
    );
  end

  scaler_snap_rdmux #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_mux (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .reg_idx  (reg_idx),
    .ts       (ts_q),
    .shadow   (shadow_q),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/scaler_snap_bank_chk.sv
module scaler_snap_bank_chk
  import scaler_snap_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int CNT_W  = 32,
  parameter int IDX_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] ev_in,
  input logic [IDX_W-1:0]  reg_idx,
  input logic              rd_en,
  input logic              wr_en,
  input logic              rd_valid,
  input logic [CNT_W-1:0]  rd_data,
  input logic [CNT_W-1:0]  ts_q,
  input logic [CNT_W-1:0]  cnt_q    [NUM_CH],
  input logic [CNT_W-1:0]  shadow_q [NUM_CH]
);
  logic ts_hit;
  assign ts_hit = (int'(reg_idx) == TS_INDEX);

  AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ts_q == $past(ts_q) + 1'b1); // R2

  AST_TS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ts_hit) |=> rd_data == $past(ts_q)); // R3

  AST_RD_VALID_HI: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R9

  AST_RD_VALID_LO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid); // R9

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    AST_SNAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && ts_hit) |=> shadow_q[i] == $past(cnt_q[i])); // R4

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && ts_hit) |=> $stable(shadow_q[i])); // R4

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && ts_hit) |=>
        cnt_q[i] == $past(cnt_q[i]) + CNT_W'($past(ev_in[i]))); // R5

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ts_hit) |=> cnt_q[i] == CNT_W'($past(ev_in[i]))); // R6
  end
endmodule

bind scaler_snap_bank scaler_snap_bank_chk #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ev_in    (ev_in),
  .reg_idx  (reg_idx),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .ts_q     (ts_q),
  .cnt_q    (cnt_q),
  .shadow_q (shadow_q)
);

// File: tb/scaler_snap_bank_tb.sv
module scaler_snap_bank_tb;
  localparam int NCH = 32;
  localparam int W   = 32;
  localparam int IW  = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] ev_in = '0;
  logic [IW-1:0]  reg_idx = '0;
  logic           rd_en = 1'b0;
  logic           wr_en = 1'b0;
  logic           rd_valid;
  logic [W-1:0]   rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [W-1:0] m_ts;
  logic [W-1:0] m_cnt [NCH];
  logic [W-1:0] m_sh  [NCH];

  always #10 clk = ~clk;

  scaler_snap_bank u_dut (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .reg_idx(reg_idx),
    .rd_en(rd_en), .wr_en(wr_en), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [W-1:0] exp_read(input int idx);
    if (idx == 6) return m_ts;                       // R3
    if (idx >= 16 && idx < 16 + NCH) return m_sh[idx-16]; // R7
    return '0;                                       // R8
  endfunction

  function automatic string tag_of(input int idx);
    if (idx == 6) return "R3";
    if (idx >= 16 && idx < 16 + NCH) return "R7";
    return "R8";
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: drive after a negedge, model at the posedge, check at the next negedge
  task automatic cycle(input logic [NCH-1:0] ev, input int idx, input bit rd,
                       input bit wr, input string tag);
    logic [W-1:0] e;
    ev_in = ev; reg_idx = IW'(idx); rd_en = rd; wr_en = wr;
    @(posedge clk);
    e = exp_read(idx);
    for (int i = 0; i < NCH; i++) begin
      if (rd && idx == 6) m_sh[i] = m_cnt[i];               // R4
      if (wr && idx == 6) m_cnt[i] = W'(ev[i]);             // R6
      else                m_cnt[i] = m_cnt[i] + W'(ev[i]);  // R5
    end
    m_ts = m_ts + 1'b1;                                     // R2
    @(negedge clk);
    check("R9", W'(rd_valid), W'(rd));
    if (rd) check(tag.len() > 0 ? tag : tag_of(idx), rd_data, e);
  endtask

  task automatic read_all_shadows(input string tag);
    for (int k = 0; k < NCH; k++) cycle('0, 16 + k, 1'b1, 1'b0, tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    m_ts = '0;
    for (int i = 0; i < NCH; i++) begin m_cnt[i] = '0; m_sh[i] = '0; end
    repeat (3) @(negedge clk);
    check("R1", W'(rd_valid), '0);
    rst_n = 1'b1;

    // R1: shadows zero after reset, timestamp starts at zero
    cycle('0, 16, 1'b1, 1'b0, "R1");
    cycle('0, 47, 1'b1, 1'b0, "R1");
    cycle('0, 6, 1'b1, 1'b0, "R2");

    // R5: count a known pattern, then snapshot and read all
    for (int n = 0; n < 5; n++) cycle(32'hA5A5_0F0F, 0, 1'b0, 1'b0, "");
    cycle(32'hFFFF_FFFF, 6, 1'b1, 1'b0, "R4");   // event in snapshot cycle not in shadow
    read_all_shadows("R5");
    cycle('0, 6, 1'b1, 1'b0, "R5");              // that event shows in next snapshot
    read_all_shadows("R5");

    // R8: write to other index has no effect; odd indexes read zero
    cycle('0, 5, 1'b0, 1'b1, "");
    cycle('0, 20, 1'b0, 1'b1, "");
    cycle('0, 15, 1'b1, 1'b0, "R8");
    cycle('0, 48, 1'b1, 1'b0, "R8");
    cycle('0, 63, 1'b1, 1'b0, "R8");
    cycle('0, 0, 1'b1, 1'b0, "R8");
    cycle('0, 6, 1'b1, 1'b0, "R8");
    read_all_shadows("R8");

    // R6: clear with events in clear cycle; timestamp keeps running
    for (int n = 0; n < 3; n++) cycle(32'h0000_FFFF, 0, 1'b0, 1'b0, "");
    cycle(32'h8000_0001, 6, 1'b0, 1'b1, "");
    cycle('0, 6, 1'b1, 1'b0, "R6");
    read_all_shadows("R6");

    // R9: read and write of index 6 together, with events
    for (int n = 0; n < 4; n++) cycle(32'h3C3C_3C3C, 0, 1'b0, 1'b0, "");
    cycle(32'h0101_0101, 6, 1'b1, 1'b1, "R9");
    read_all_shadows("R9");
    cycle('0, 6, 1'b1, 1'b0, "R9");
    read_all_shadows("R9");

    // Random mix: events, snapshots, clears, shadow and stray reads
    for (int n = 0; n < 4000; n++) begin
      logic [NCH-1:0] ev;
      int sel, idx;
      bit rd, wr;
      ev  = (n % 3 == 0) ? $urandom() : ($urandom() & $urandom());
      sel = $urandom_range(0, 9);
      rd  = 1'b0; wr = 1'b0; idx = 0;
      case (sel)
        0, 1:    begin idx = 6; rd = 1'b1; end
        2:       begin idx = 6; wr = 1'b1; end
        3:       begin idx = 6; rd = 1'b1; wr = 1'b1; end
        4, 5, 6: begin idx = 16 + $urandom_range(0, NCH - 1); rd = 1'b1; end
        7:       begin idx = $urandom_range(0, 63); rd = 1'b1; end
        8:       begin idx = $urandom_range(0, 63); wr = (idx != 6); end
        default: idx = 0;
      endcase
      cycle(ev, idx, rd, wr, "");
    end
    cycle('0, 6, 1'b1, 1'b0, "R4");
    read_all_shadows("R7");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule